// File: doc/BRIEF.md
# Shadow Address Remapping Translator

This block sits on the memory-controller side of a system bus. It takes each physical bus address and looks at the top bit. With that bit clear, the address points into real memory, which occupies the lower 2 GB of the 32-bit space, and the block hands it back unchanged. With that bit set, the address belongs to shadow space. The block then translates it one 4 KB page at a time into a real address. This lets a run of contiguous, aligned shadow pages land on real frames scattered anywhere in memory. One large processor page can therefore cover memory that is not contiguous.

Seven region descriptors are compared in parallel against each shadow address. Each descriptor holds three things: which aligned shadow region it covers, where that region's page table starts, and how many entries the table has. After a match, a fully associative translation cache is searched for the shadow page number. On a miss, the block issues exactly one read to the page table over a valid/ready read port. It stores the returned frame in the cache slot named by a round-robin pointer, then answers the request. A request that matches no region, or whose page falls past the end of its table, gets an error answer and causes no read. Writing a descriptor drops every cached translation of that region.

Top module: `shadow_remap_xlate`

## Requirements
- R1: An address with bit 31 clear is returned on `rsp_addr` unchanged, with `rsp_err` low, and causes no page-table read.
- R2: A shadow address matches descriptor k when k has been written and address bits [31:12+RSPAN_LOG2] equal that descriptor's `cfg_region`. When several descriptors match, the lowest-numbered one is used.
- R3: A shadow address that matches no descriptor answers with `rsp_err` high and `rsp_addr` zero, and causes no page-table read.
- R4: The page index is address bits [12+RSPAN_LOG2-1:12]. An index equal to or above the descriptor's table size answers with an error and causes no read. An index one below the size is translated.
- R5: The page-table read address equals the table base plus four times the page index.
- R6: A translated answer is the frame, taken from `pt_rsp_data` bits [19:0], placed in bits [31:12], with address bits [11:0] carried through unchanged.
- R7: A cache miss issues exactly one page-table read and fills the cache. A later access to the same shadow page, at any offset, is answered with no read.
- R8: Fills go to cache slots in round-robin order. With N slots, the (N+1)th distinct miss evicts the first page filled.
- R9: Writing a descriptor drops the cached pages of that region only. Pages of other regions still hit.
- R10: If the descriptor of the region being fetched is written while the read is outstanding, the request still completes with the fetched frame, but that frame is not cached.
- R11: `req_ready` is high only while no request is in progress. `rsp_valid`, `rsp_addr` and `rsp_err` hold steady until `rsp_ready`. `pt_rd_valid` and `pt_rd_addr` hold steady until `pt_rd_ready`.
- R12: After reset, `req_ready` is high, `rsp_valid` and `pt_rd_valid` are low, no descriptor matches and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Incoming bus address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Real physical address |
| rsp_err | output | 1 | No region matched, or the index is out of table range |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 3 | Descriptor number, 0 to 6 (higher values are ignored) |
| cfg_region | input | 4 | Shadow region number (address bits 31:28) |
| cfg_tbl_base | input | 32 | Page-table base byte address |
| cfg_tbl_size | input | 17 | Page-table entry count |
| pt_rd_valid | output | 1 | Page-table read request |
| pt_rd_ready | input | 1 | Read request accepted |
| pt_rd_addr | output | 32 | Page-table entry byte address |
| pt_rsp_valid | input | 1 | Page-table read data valid |
| pt_rsp_data | input | 20 | Frame number returned by the table |

## Verification
Two things can happen in the same cycle: a descriptor write and the refill of that same region, whose read is still outstanding. The bench starts a miss against a page-table model with a long latency. It then writes the region's descriptor, with a new table base, while the read is in flight. The answer must carry the frame from the old table. The next access to that page must issue a fresh read at the new base, which shows the stale frame never entered the cache. A separate case checks that a write to one region leaves another region's cached page hitting.

// File: rtl/shx_pkg.sv
package shx_pkg;
  localparam int ADDR_W   = 32;
  localparam int PG_OFS_W = 12;
  localparam int SPG_W    = ADDR_W - PG_OFS_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } xl_state_e;
endpackage

// File: rtl/shx_desc_bank.sv
module shx_desc_bank
  import shx_pkg::*;
#(
  parameter int NUM_REGIONS = 7,
  parameter int RSPAN_LOG2  = 16,
  parameter int RID_W       = 3,
  parameter int TSIZE_W     = 17,
  parameter int TAG_W       = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [RID_W-1:0]   cfg_idx,
  input  logic [TAG_W-1:0]   cfg_region,
  input  logic [ADDR_W-1:0]  cfg_tbl_base,
  input  logic [TSIZE_W-1:0] cfg_tbl_size,
  input  logic [SPG_W-1:0]   lk_page,
  output logic               match,
  output logic [RID_W-1:0]   match_rid,
  output logic               idx_oob,
  output logic [ADDR_W-1:0]  pte_addr
);
  logic [NUM_REGIONS-1:0] d_vld;
  logic [TAG_W-1:0]       d_tag  [NUM_REGIONS];
  logic [ADDR_W-1:0]      d_base [NUM_REGIONS];
  logic [TSIZE_W-1:0]     d_size [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hit_vec;
  logic                   wr_ok;
  logic [ADDR_W-1:0]      sel_base;
  logic [TSIZE_W-1:0]     sel_size;
  logic [RSPAN_LOG2-1:0]  pg_idx;

  assign wr_ok  = cfg_we && ({1'b0, cfg_idx} < (RID_W+1)'(NUM_REGIONS));
  assign pg_idx = lk_page[RSPAN_LOG2-1:0];

  // descriptor storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_vld <= '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
        d_tag[i]  <= '0;
        d_base[i] <= '0;
        d_size[i] <= '0;
      end
    end else if (wr_ok) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (cfg_idx == RID_W'(i)) begin
          d_vld[i]  <= 1'b1;
          d_tag[i]  <= cfg_region;
          d_base[i] <= cfg_tbl_base;
          d_size[i] <= cfg_tbl_size;
        end
      end
    end
  end

  // parallel region compare
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    assign hit_vec[g] = d_vld[g] && (lk_page[SPG_W-1 -: TAG_W] == d_tag[g]);
  end

  // lowest index wins
  always_comb begin
    match     = 1'b0;
    match_rid = '0;
    sel_base  = '0;
    sel_size  = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        match     = 1'b1;
        match_rid = RID_W'(i);
        sel_base  = d_base[i];
        sel_size  = d_size[i];
      end
    end
  end

  assign idx_oob  = TSIZE_W'(pg_idx) >= sel_size;
  assign pte_addr = sel_base + ADDR_W'({pg_idx, 2'b00});

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (hit_vec[match_rid] &&
               ((hit_vec & NUM_REGIONS'((1 << match_rid) - 1)) == '0))); // R2
endmodule

// File: rtl/shx_tcache.sv
module shx_tcache
  import shx_pkg::*;
#(
  parameter int ENTRIES = 1024,
  parameter int RID_W   = 3,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SPG_W-1:0]   lk_page,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_en,
  input  logic [SPG_W-1:0]   fill_page,
  input  logic [RID_W-1:0]   fill_rid,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               inv_en,
  input  logic [RID_W-1:0]   inv_rid
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] e_vld;
  logic [SPG_W-1:0]   e_tag   [ENTRIES];
  logic [RID_W-1:0]   e_rid   [ENTRIES];
  logic [FRAME_W-1:0] e_frame [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   ptr_q, ptr_d;

  // round-robin victim pointer
  always_comb begin
    ptr_d = ptr_q;
    if (fill_en) begin
      ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (fill_en) begin
      ptr_q <= ptr_d;
    end
  end

  // valid bits: fill sets, region invalidate clears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_en && ptr_q == IDX_W'(i)) begin
          e_vld[i] <= 1'b1;
        end else if (inv_en && e_rid[i] == inv_rid) begin
          e_vld[i] <= 1'b0;
        end
      end
    end
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (fill_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ptr_q == IDX_W'(i)) begin
          e_tag[i]   <= fill_page;
          e_rid[i]   <= fill_rid;
          e_frame[i] <= fill_frame;
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tag
    assign hit_vec[g] = e_vld[g] && (e_tag[g] == lk_page);
  end

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) lk_frame = lk_frame | e_frame[i];
    end
  end

  assign lk_hit = |hit_vec;

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) <= 1); // R7
endmodule

// File: rtl/shadow_remap_xlate.sv
module shadow_remap_xlate
  import shx_pkg::*;
#(
  parameter int NUM_REGIONS   = 7,
  parameter int RSPAN_LOG2    = 16,
  parameter int CACHE_ENTRIES = 1024
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [31:0]           req_addr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [31:0]           rsp_addr,
  output logic                  rsp_err,
  input  logic                  cfg_we,
  input  logic [$clog2(NUM_REGIONS)-1:0] cfg_idx,
  input  logic [SPG_W-RSPAN_LOG2-1:0]    cfg_region,
  input  logic [31:0]           cfg_tbl_base,
  input  logic [RSPAN_LOG2:0]   cfg_tbl_size,
  output logic                  pt_rd_valid,
  input  logic                  pt_rd_ready,
  output logic [31:0]           pt_rd_addr,
  input  logic                  pt_rsp_valid,
  input  logic [SPG_W-1:0]      pt_rsp_data
);
  localparam int RID_W   = $clog2(NUM_REGIONS);
  localparam int TAG_W   = SPG_W - RSPAN_LOG2;
  localparam int TSIZE_W = RSPAN_LOG2 + 1;
  localparam int FRAME_W = SPG_W;

  xl_state_e          state_q, state_d;
  logic [ADDR_W-1:0]  cur_addr_q, cur_addr_d;
  logic [RID_W-1:0]   rid_q, rid_d;
  logic [ADDR_W-1:0]  pte_q, pte_d;
  logic [ADDR_W-1:0]  out_addr_q, out_addr_d;
  logic               out_err_q, out_err_d;
  logic               stale_q, stale_d;

  logic               desc_match, desc_oob;
  logic [RID_W-1:0]   desc_rid;
  logic [ADDR_W-1:0]  desc_pte;
  logic               c_hit;
  logic [FRAME_W-1:0] c_frame;
  logic               fill_en;
  logic               cfg_ok;
  logic               cfg_hits_cur;
  logic [SPG_W-1:0]   cur_page;
  logic [PG_OFS_W-1:0] cur_ofs;

  assign cur_page     = cur_addr_q[ADDR_W-1:PG_OFS_W];
  assign cur_ofs      = cur_addr_q[PG_OFS_W-1:0];
  assign cfg_ok       = cfg_we && ({1'b0, cfg_idx} < (RID_W+1)'(NUM_REGIONS));
  assign cfg_hits_cur = cfg_ok && (cfg_idx == rid_q);

  shx_desc_bank #(
    .NUM_REGIONS (NUM_REGIONS),
    .RSPAN_LOG2  (RSPAN_LOG2),
    .RID_W       (RID_W),
    .TSIZE_W     (TSIZE_W),
    .TAG_W       (TAG_W)
  ) u_desc (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_idx      (cfg_idx),
    .cfg_region   (cfg_region),
    .cfg_tbl_base (cfg_tbl_base),
    .cfg_tbl_size (cfg_tbl_size),
    .lk_page      (cur_page),
    .match        (desc_match),
    .match_rid    (desc_rid),
    .idx_oob      (desc_oob),
    .pte_addr     (desc_pte)
  );

  shx_tcache #(
    .ENTRIES (CACHE_ENTRIES),
    .RID_W   (RID_W),
    .FRAME_W (FRAME_W)
  ) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_page    (cur_page),
    .lk_hit     (c_hit),
    .lk_frame   (c_frame),
    .fill_en    (fill_en),
    .fill_page  (cur_page),
    .fill_rid   (rid_q),
    .fill_frame (pt_rsp_data),
    .inv_en     (cfg_ok),
    .inv_rid    (cfg_idx)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    cur_addr_d = cur_addr_q;
    rid_d      = rid_q;
    pte_d      = pte_q;
    out_addr_d = out_addr_q;
    out_err_d  = out_err_q;
    stale_d    = stale_q;
    fill_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cur_addr_d = req_addr;
          state_d    = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!cur_addr_q[ADDR_W-1]) begin
          out_addr_d = cur_addr_q;
          out_err_d  = 1'b0;
          state_d    = ST_RESP;
        end else if (!desc_match || desc_oob) begin
          out_addr_d = '0;
          out_err_d  = 1'b1;
          state_d    = ST_RESP;
        end else if (c_hit) begin
          out_addr_d = {c_frame, cur_ofs};
          out_err_d  = 1'b0;
          state_d    = ST_RESP;
        end else begin
          rid_d   = desc_rid;
          pte_d   = desc_pte;
          stale_d = cfg_ok && (cfg_idx == desc_rid);
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        stale_d = stale_q || cfg_hits_cur;
        if (pt_rd_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        stale_d = stale_q || cfg_hits_cur;
        if (pt_rsp_valid) begin
          out_addr_d = {pt_rsp_data, cur_ofs};
          out_err_d  = 1'b0;
          fill_en    = !(stale_q || cfg_hits_cur);
          state_d    = ST_RESP;
        end
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_addr_q <= '0;
      rid_q      <= '0;
      pte_q      <= '0;
      out_addr_q <= '0;
      out_err_q  <= 1'b0;
      stale_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      cur_addr_q <= cur_addr_d;
      rid_q      <= rid_d;
      pte_q      <= pte_d;
      out_addr_q <= out_addr_d;
      out_err_q  <= out_err_d;
      stale_q    <= stale_d;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_valid   = (state_q == ST_RESP);
  assign rsp_addr    = out_addr_q;
  assign rsp_err     = out_err_q;
  assign pt_rd_valid = (state_q == ST_FETCH);
  assign pt_rd_addr  = pte_q;

  AST_REAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !cur_addr_q[ADDR_W-1]) |-> (rsp_addr == cur_addr_q && !rsp_err)); // R1
  AST_ERR_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && cur_addr_q[ADDR_W-1] && (!desc_match || desc_oob))
      |=> (rsp_valid && rsp_err && !pt_rd_valid)); // R3
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (rsp_addr[PG_OFS_W-1:0] == cur_addr_q[PG_OFS_W-1:0])); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_err))); // R11
  AST_PT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_rd_valid && !pt_rd_ready) |=> (pt_rd_valid && $stable(pt_rd_addr))); // R11
  AST_STALE_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && stale_q) |-> !fill_en); // R10
endmodule

// File: tb/shadow_remap_xlate_tb.sv
module shadow_remap_xlate_tb;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_addr;
  logic        rsp_err;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [3:0]  cfg_region;
  logic [31:0] cfg_tbl_base;
  logic [16:0] cfg_tbl_size;
  logic        pt_rd_valid;
  logic        pt_rd_ready;
  logic [31:0] pt_rd_addr;
  logic        pt_rsp_valid;
  logic [19:0] pt_rsp_data;

  int tests;
  int fails;
  int cyc;
  int pt_reads;
  int pt_lat;
  int pend_cnt;
  logic        pend;
  logic [31:0] pend_addr;
  logic [31:0] last_pt_addr;

  shadow_remap_xlate #(
    .NUM_REGIONS   (7),
    .RSPAN_LOG2    (16),
    .CACHE_ENTRIES (4)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_addr     (rsp_addr),
    .rsp_err      (rsp_err),
    .cfg_we       (cfg_we),
    .cfg_idx      (cfg_idx),
    .cfg_region   (cfg_region),
    .cfg_tbl_base (cfg_tbl_base),
    .cfg_tbl_size (cfg_tbl_size),
    .pt_rd_valid  (pt_rd_valid),
    .pt_rd_ready  (pt_rd_ready),
    .pt_rd_addr   (pt_rd_addr),
    .pt_rsp_valid (pt_rsp_valid),
    .pt_rsp_data  (pt_rsp_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [19:0] frame_of(input logic [31:0] pte);
    return pte[21:2] ^ 20'h40138;
  endfunction

  function automatic logic [31:0] exp_xl(input logic [31:0] base, input logic [31:0] a);
    return {frame_of(base + {14'd0, a[27:12], 2'b00}), a[11:0]};
  endfunction

  // page-table memory model
  always @(posedge clk) begin
    pt_rsp_valid <= 1'b0;
    if (pend) begin
      if (pend_cnt <= 1) begin
        pt_rsp_valid <= 1'b1;
        pt_rsp_data  <= frame_of(pend_addr);
        pend         <= 1'b0;
      end else begin
        pend_cnt <= pend_cnt - 1;
      end
    end
    if (pt_rd_valid && pt_rd_ready) begin
      pt_reads     <= pt_reads + 1;
      last_pt_addr <= pt_rd_addr;
      pend         <= 1'b1;
      pend_cnt     <= pt_lat;
      pend_addr    <= pt_rd_addr;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL R11 watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] idx, input logic [3:0] reg_n,
                        input logic [31:0] base, input logic [16:0] size);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_region = reg_n;
    cfg_tbl_base = base; cfg_tbl_size = size;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] a, output logic [31:0] ra,
                       output logic err, output int nrd);
    int r0;
    r0 = pt_reads;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    ra  = rsp_addr;
    err = rsp_err;
    @(negedge clk);
    nrd = pt_reads - r0;
  endtask

  task automatic t_reset;
    logic [31:0] ra; logic e; int n;
    chk("R12", "req_ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R12", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R12", "pt_rd_valid after reset", {31'd0, pt_rd_valid}, 32'd0);
    xlate(32'h8000_0040, ra, e, n);
    chk("R12", "unprogrammed descriptor err", {31'd0, e}, 32'd1);
    chk("R12", "unprogrammed reads", n, 0);
  endtask

  task automatic t_real;
    logic [31:0] ra; logic e; int n;
    xlate(32'h1234_5678, ra, e, n);
    chk("R1", "real pass addr", ra, 32'h1234_5678);
    chk("R1", "real pass err", {31'd0, e}, 32'd0);
    chk("R1", "real pass reads", n, 0);
    xlate(32'h7FFF_FFFF, ra, e, n);
    chk("R1", "top real addr", ra, 32'h7FFF_FFFF);
  endtask

  task automatic t_nomatch;
    logic [31:0] ra; logic e; int n;
    xlate(32'hA000_1234, ra, e, n);
    chk("R3", "no match err", {31'd0, e}, 32'd1);
    chk("R3", "no match addr zero", ra, 32'd0);
    chk("R3", "no match reads", n, 0);
  endtask

  task automatic t_bounds;
    logic [31:0] ra; logic e; int n;
    xlate(32'h8010_0000, ra, e, n);
    chk("R4", "index at size err", {31'd0, e}, 32'd1);
    chk("R4", "index at size reads", n, 0);
    xlate(32'h800F_F004, ra, e, n);
    chk("R4", "last index ok", {31'd0, e}, 32'd0);
    chk("R5", "last index pte", last_pt_addr, 32'h0010_03FC);
    chk("R6", "last index addr", ra, exp_xl(32'h0010_0000, 32'h800F_F004));
  endtask

  task automatic t_miss_hit;
    logic [31:0] ra; logic e; int n;
    xlate(32'h9024_0080, ra, e, n);
    chk("R7", "miss reads", n, 1);
    chk("R2", "lowest descriptor pte", last_pt_addr, 32'h0020_0900);
    chk("R6", "miss addr", ra, exp_xl(32'h0020_0000, 32'h9024_0080));
    xlate(32'h9024_0080, ra, e, n);
    chk("R7", "hit reads", n, 0);
    chk("R7", "hit addr", ra, exp_xl(32'h0020_0000, 32'h9024_0080));
    xlate(32'h9024_0FFF, ra, e, n);
    chk("R6", "hit other offset", ra, exp_xl(32'h0020_0000, 32'h9024_0FFF));
    chk("R7", "hit other offset reads", n, 0);
  endtask

  task automatic t_round_robin;
    logic [31:0] ra; logic e; int n;
    cfg_wr(3'd0, 4'h8, 32'h0010_0000, 17'h00100);
    cfg_wr(3'd1, 4'h9, 32'h0020_0000, 17'h10000);
    for (int p = 1; p <= 5; p++) begin
      xlate(32'h9000_0000 + (p << 12), ra, e, n);
      chk("R8", "fill sequence reads", n, 1);
    end
    xlate(32'h9000_1000, ra, e, n);
    chk("R8", "first page evicted", n, 1);
    xlate(32'h9000_3000, ra, e, n);
    chk("R8", "third page kept", n, 0);
    xlate(32'h9000_2000, ra, e, n);
    chk("R8", "second page evicted by refill", n, 1);
  endtask

  task automatic t_invalidate;
    logic [31:0] ra; logic e; int n;
    xlate(32'h8000_2000, ra, e, n);
    xlate(32'h9000_7000, ra, e, n);
    cfg_wr(3'd0, 4'h8, 32'h0010_0000, 17'h00100);
    xlate(32'h8000_2000, ra, e, n);
    chk("R9", "rewritten region refetch", n, 1);
    xlate(32'h9000_7000, ra, e, n);
    chk("R9", "other region still hits", n, 0);
  endtask

  task automatic t_race;
    logic [31:0] ra; logic e; int n;
    pt_lat = 5;
    fork
      xlate(32'h8000_3010, ra, e, n);
      begin
        repeat (3) @(negedge clk);
        cfg_wr(3'd0, 4'h8, 32'h0040_0000, 17'h00100);
      end
    join
    pt_lat = 1;
    chk("R10", "in-flight answer old frame", ra, exp_xl(32'h0010_0000, 32'h8000_3010));
    xlate(32'h8000_3010, ra, e, n);
    chk("R10", "stale frame not cached", n, 1);
    chk("R10", "refetch from new base", last_pt_addr, 32'h0040_000C);
    chk("R10", "new frame", ra, exp_xl(32'h0040_0000, 32'h8000_3010));
  endtask

  task automatic t_hold;
    logic [31:0] a0;
    pt_ready_i_set(1'b0);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h9000_9044;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "pt request held", {31'd0, pt_rd_valid}, 32'd1);
    chk("R11", "pt addr held", pt_rd_addr, 32'h0020_0024);
    chk("R11", "busy not ready", {31'd0, req_ready}, 32'd0);
    pt_ready_i_set(1'b1);
    while (!rsp_valid) @(negedge clk);
    a0 = rsp_addr;
    repeat (3) @(negedge clk);
    chk("R11", "response held", {31'd0, rsp_valid}, 32'd1);
    chk("R11", "response addr stable", rsp_addr, a0);
    chk("R6", "stalled miss addr", a0, exp_xl(32'h0020_0000, 32'h9000_9044));
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11", "response released", {31'd0, rsp_valid}, 32'd0);
    chk("R11", "ready again", {31'd0, req_ready}, 32'd1);
  endtask

  logic pt_ready_i;
  assign pt_rd_ready = pt_ready_i;

  task automatic pt_ready_i_set(input logic v);
    pt_ready_i = v;
  endtask

  initial begin
    tests = 0; fails = 0; cyc = 0; pt_reads = 0; pt_lat = 1;
    pend = 1'b0; pend_cnt = 0; pend_addr = '0; last_pt_addr = '0;
    pt_rsp_data = '0; pt_ready_i = 1'b1;
    req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b1;
    cfg_we = 1'b0; cfg_idx = '0; cfg_region = '0; cfg_tbl_base = '0; cfg_tbl_size = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_wr(3'd0, 4'h8, 32'h0010_0000, 17'h00100);
    cfg_wr(3'd1, 4'h9, 32'h0020_0000, 17'h10000);
    cfg_wr(3'd2, 4'h9, 32'h0030_0000, 17'h10000);
    t_real();
    t_nomatch();
    t_bounds();
    t_miss_hit();
    t_round_robin();
    t_invalidate();
    t_race();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule